// File: doc/BRIEF.md
# Accelerator Instruction Decoder and Sequencer

This block takes a stream of 32-bit instruction words on a valid/ready input and turns them into three kinds of action. It writes values into a bank of configuration registers that feed the compute engine. It issues read or write requests to a separate data-mover. It starts the compute engine and then waits for it to finish. The upper byte of every word is a class header. The lower 24 bits carry that class's payload.

Every instruction block has a fixed shape. An opening handshake comes first, followed by configuration words. A separating handshake comes next, followed by data-movement words. A closing handshake ends the block. The closing handshake starts the compute engine. A data-movement request does not fit in one word, so it is built from three consecutive words: the address high part, the address low part, and the length with its direction. The request goes out only when the third word arrives.

The sequencer stops accepting words while a transfer or a compute run is still outstanding. A header outside the defined set, or any word in the wrong place, sets a sticky error flag and freezes the decoder until reset.

Top module: `instr_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `in_ready` is 1, `err` is 0, `dma_req` and `comp_start` are 0, and every configuration register reads 0.
- R2: Header 0x20 writes bits [15:0] into the configuration register selected by bits [23:16]. The write is accepted only between the opening and separating handshakes. The new value appears on `cfg_regs` in the cycle after the word is accepted, at slice `[idx*16 +: 16]`.
- R3: A configuration word whose index in bits [23:16] is 8 or more sets `err` and writes no register.
- R4: The handshake headers are 0xF0 (open), 0xF1 (separate) and 0xF2 (close). Opening is accepted only when idle. Separating is accepted only in the configuration phase. Closing is accepted only in the data-movement phase when no address chain is partly received. Any other placement of a handshake, configuration or data-movement word sets `err`.
- R5: A word whose header is not one of 0xF0, 0xF1, 0xF2, 0x20, 0x30, 0x31, 0x32 or 0x33 sets `err` in the cycle after it is accepted.
- R6: A transfer is the sequence 0x30 (bits [15:0] become address bits [39:24]), then 0x31 (bits [23:0] become address bits [23:0]), then 0x32 for a read or 0x33 for a write (bits [23:0] are the length). `dma_req` pulses for exactly one cycle, in the cycle after the third word is accepted. In that cycle the full address, the length and `dma_wr` (1 for write) are valid. These outputs change only together with a request. A chain word out of this order sets `err`.
- R7: From the request cycle until the cycle in which `dma_done` is seen high, `in_ready` is 0. It returns to 1 in the following cycle.
- R8: An accepted closing handshake pulses `comp_start` for one cycle. `in_ready` then stays 0 until `comp_done` is seen high, after which the sequencer is idle and expects an opening handshake.
- R9: Once `err` is set, it stays set and `in_ready` stays 0, whatever arrives on the inputs, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word valid |
| in_data | input | 32 | Instruction word, header in [31:24] |
| in_ready | output | 1 | Sequencer can take a word this cycle |
| cfg_regs | output | NREG*CFG_W | Configuration register bank, register i at [i*CFG_W +: CFG_W] |
| dma_req | output | 1 | One-cycle transfer request |
| dma_addr | output | ADDR_W | Transfer address |
| dma_len | output | LEN_W | Transfer length |
| dma_wr | output | 1 | Transfer direction, 1 = write |
| dma_done | input | 1 | Data-mover finished the outstanding transfer |
| comp_start | output | 1 | One-cycle compute start |
| comp_done | input | 1 | Compute engine finished |
| err | output | 1 | Sticky protocol error |

## Verification
The hardest situations to reach from the ports are the partly received address chain and the waits. Examples are a closing handshake that lands after only the high address word, or a low word that arrives before any high word. Another is an instruction held valid for many cycles while a transfer or a compute run is outstanding. The stimulus reaches these with short, deliberately broken blocks, each followed by a reset. The bench's data-mover and compute responders use adjustable latencies, so words are offered continuously while the sequencer is blocked. A queue-based reference model predicts every output on every cycle, so a word accepted too early shows up at once as a mismatch.

// File: rtl/instr_seq.sv
module instr_seq #(
  parameter int NREG   = 8,
  parameter int CFG_W  = 16,
  parameter int ADDR_W = 40,
  parameter int LEN_W  = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [31:0]             in_data,
  output logic                    in_ready,
  output logic [NREG*CFG_W-1:0]   cfg_regs,
  output logic                    dma_req,
  output logic [ADDR_W-1:0]       dma_addr,
  output logic [LEN_W-1:0]        dma_len,
  output logic                    dma_wr,
  input  logic                    dma_done,
  output logic                    comp_start,
  input  logic                    comp_done,
  output logic                    err
);
  localparam int AHI_W = ADDR_W - 24;
  localparam int IDX_W = $clog2(NREG);
  localparam logic [7:0] NREG8 = 8'(NREG);

  localparam logic [7:0] H_OPEN  = 8'hF0;
  localparam logic [7:0] H_SPLIT = 8'hF1;
  localparam logic [7:0] H_CLOSE = 8'hF2;
  localparam logic [7:0] H_CFG   = 8'h20;
  localparam logic [7:0] H_AHI   = 8'h30;
  localparam logic [7:0] H_ALO   = 8'h31;
  localparam logic [7:0] H_LRD   = 8'h32;
  localparam logic [7:0] H_LWR   = 8'h33;

  typedef enum logic [2:0] {S_IDLE, S_CFG, S_MOV, S_DWAIT, S_CWAIT, S_ERR} st_t;

  st_t              state;
  logic [1:0]       step;
  logic [AHI_W-1:0] ahi;
  logic [23:0]      alo;
  logic [CFG_W-1:0] cfg_q [NREG];
  logic             bad;

  wire [7:0] hdr = in_data[31:24];
  wire       acc = in_valid & in_ready;

  assign in_ready = (state == S_IDLE) || (state == S_CFG) || (state == S_MOV);

  for (genvar i = 0; i < NREG; i++) begin : g_cfg
    assign cfg_regs[i*CFG_W +: CFG_W] = cfg_q[i];
  end

  always_comb begin
    case (hdr)
      H_OPEN:        bad = state != S_IDLE;
      H_SPLIT:       bad = state != S_CFG;
      H_CLOSE:       bad = (state != S_MOV) || (step != 2'd0);
      H_CFG:         bad = (state != S_CFG) || (in_data[23:16] >= NREG8);
      H_AHI:         bad = (state != S_MOV) || (step != 2'd0);
      H_ALO:         bad = (state != S_MOV) || (step != 2'd1);
      H_LRD, H_LWR:  bad = (state != S_MOV) || (step != 2'd2);
      default:       bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      step       <= 2'd0;
      ahi        <= '0;
      alo        <= '0;
      dma_req    <= 1'b0;
      dma_addr   <= '0;
      dma_len    <= '0;
      dma_wr     <= 1'b0;
      comp_start <= 1'b0;
      err        <= 1'b0;
      for (int i = 0; i < NREG; i++) cfg_q[i] <= '0;
    end else begin
      dma_req    <= 1'b0;
      comp_start <= 1'b0;
      case (state)
        S_DWAIT: if (dma_done)  state <= S_MOV;
        S_CWAIT: if (comp_done) state <= S_IDLE;
        S_ERR:   state <= S_ERR;
        default: if (acc) begin
          if (bad) begin
            state <= S_ERR;
            err   <= 1'b1;
          end else begin
            case (hdr)
              H_OPEN:  state <= S_CFG;
              H_SPLIT: state <= S_MOV;
              H_CLOSE: begin
                state      <= S_CWAIT;
                comp_start <= 1'b1;
              end
              H_CFG:   cfg_q[in_data[16 +: IDX_W]] <= in_data[CFG_W-1:0];
              H_AHI: begin
                ahi  <= in_data[AHI_W-1:0];
                step <= 2'd1;
              end
              H_ALO: begin
                alo  <= in_data[23:0];
                step <= 2'd2;
              end
              default: begin
                dma_req  <= 1'b1;
                dma_addr <= {ahi, alo};
                dma_len  <= in_data[LEN_W-1:0];
                dma_wr   <= hdr == H_LWR;
                step     <= 2'd0;
                state    <= S_DWAIT;
              end
            endcase
          end
        end
      endcase
    end
  end

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r9_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !in_ready);

  a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);

  a_r6_addr_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dma_addr) |-> dma_req);

  a_r7_hold_during_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_done) |=> !in_ready);

  a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    comp_start |=> !comp_start);

  a_r8_hold_during_comp: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_start && !comp_done) |=> !in_ready);

endmodule

// File: tb/sim_instr_seq.sv
`timescale 1ns/1ps
module sim_instr_seq;
  localparam int NR = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  in_data = '0;
  logic         in_ready;
  logic [127:0] cfg_regs;
  logic         dma_req;
  logic [39:0]  dma_addr;
  logic [23:0]  dma_len;
  logic         dma_wr;
  logic         dma_done = 1'b0;
  logic         comp_start;
  logic         comp_done = 1'b0;
  logic         err;

  int n_vec = 0;
  int n_bad = 0;
  int dma_lat = 3;
  int comp_lat = 4;
  int dcnt = 0;
  int ccnt = 0;

  instr_seq u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cfg_regs(cfg_regs), .dma_req(dma_req),
    .dma_addr(dma_addr), .dma_len(dma_len), .dma_wr(dma_wr),
    .dma_done(dma_done), .comp_start(comp_start), .comp_done(comp_done),
    .err(err)
  );

  always #2.5 clk = ~clk;

  // reference model: phase 0 idle, 1 config, 2 move, 3 wait dma, 4 wait compute, 5 error
  int          ph = 0;
  logic [31:0] chain [$];
  logic [15:0] m_cfg [NR];
  logic        m_req = 0, m_wr = 0, m_start = 0, m_err = 0;
  logic [39:0] m_addr = '0;
  logic [23:0] m_len = '0;

  initial for (int i = 0; i < NR; i++) m_cfg[i] = '0;

  task automatic model_word(input logic [31:0] w);
    logic [7:0] h;
    bit ok;
    h = w[31:24];
    case (h)
      8'hF0: ok = ph == 0;
      8'hF1: ok = ph == 1;
      8'hF2: ok = ph == 2 && chain.size() == 0;
      8'h20: ok = ph == 1 && w[23:16] < 8'd8;
      8'h30: ok = ph == 2 && chain.size() == 0;
      8'h31: ok = ph == 2 && chain.size() == 1;
      8'h32, 8'h33: ok = ph == 2 && chain.size() == 2;
      default: ok = 0;
    endcase
    if (!ok) begin
      ph = 5;
      m_err = 1;
    end else begin
      case (h)
        8'hF0: ph = 1;
        8'hF1: ph = 2;
        8'hF2: begin ph = 4; m_start = 1; end
        8'h20: m_cfg[w[18:16]] = w[15:0];
        8'h30, 8'h31: chain.push_back(w);
        default: begin
          m_req  = 1;
          m_addr = {chain[0][15:0], chain[1][23:0]};
          m_len  = w[23:0];
          m_wr   = h == 8'h33;
          chain.delete();
          ph = 3;
        end
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0;
      chain.delete();
      for (int i = 0; i < NR; i++) m_cfg[i] = '0;
      m_req = 0; m_wr = 0; m_start = 0; m_err = 0;
      m_addr = '0; m_len = '0;
    end else begin
      m_req = 0;
      m_start = 0;
      if (ph == 3) begin
        if (dma_done) ph = 2;
      end else if (ph == 4) begin
        if (comp_done) ph = 0;
      end else if (ph < 3 && in_valid) begin
        model_word(in_data);
      end
    end
  end

  task automatic cmp(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic string ready_tag();
    if (ph == 3) return "R7 in_ready";
    if (ph == 4) return "R8 in_ready";
    if (ph == 5) return "R9 in_ready";
    return "R4 in_ready";
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic [127:0] ecfg;
      for (int i = 0; i < NR; i++) ecfg[i*16 +: 16] = m_cfg[i];
      cmp(ready_tag(), 128'(in_ready), 128'(ph < 3));
      cmp("R5 err", 128'(err), 128'(m_err));
      cmp("R2 cfg_regs", cfg_regs, ecfg);
      cmp("R6 dma_req", 128'(dma_req), 128'(m_req));
      cmp("R6 dma_addr", 128'(dma_addr), 128'(m_addr));
      cmp("R6 dma_len", 128'(dma_len), 128'(m_len));
      cmp("R6 dma_wr", 128'(dma_wr), 128'(m_wr));
      cmp("R8 comp_start", 128'(comp_start), 128'(m_start));
    end
  end

  // data-mover and compute responders
  always @(negedge clk) begin
    dma_done = 0;
    if (dcnt > 0) begin
      dcnt--;
      if (dcnt == 0) dma_done = 1;
    end
    if (dma_req) dcnt = dma_lat;
    comp_done = 0;
    if (ccnt > 0) begin
      ccnt--;
      if (ccnt == 0) comp_done = 1;
    end
    if (comp_start) ccnt = comp_lat;
  end

  task automatic send(input logic [31:0] w);
    bit r;
    in_valid = 1;
    in_data = w;
    for (int n = 0; n < 40; n++) begin
      r = in_ready;
      @(posedge clk);
      @(negedge clk);
      if (r) break;
    end
    in_valid = 0;
    in_data = 32'hDEAD_0000;
  endtask

  task automatic do_reset();
    rst_n = 0;
    dcnt = 0;
    ccnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic expect_err(input string tag);
    repeat (2) @(negedge clk);
    cmp(tag, {126'd0, err, in_ready}, 128'b10);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    cmp("R1 reset outputs", {cfg_regs[7:0], 3'b0, in_ready, err, dma_req, comp_start, 1'b0},
        {8'h00, 3'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});
    cmp("R1 reset cfg", cfg_regs, '0);
    rst_n = 1;
    @(negedge clk);
    cmp("R1 after release", {125'd0, in_ready, err, dma_req}, 128'b100);

    // full block, reads and writes
    send(32'hF000_0000);
    send(32'h2000_1234);
    send(32'h2007_BEEF);
    send(32'h2003_00A5);
    send(32'h2003_5A5A);
    @(negedge clk);
    cmp("R2 cfg index 3 overwrite", 128'(cfg_regs[3*16 +: 16]), 128'h5A5A);
    send(32'hF100_0000);
    send(32'h3000_00AB);
    send(32'h3112_3456);
    send(32'h3200_0100);
    dma_lat = 7;
    send(32'h3000_FFFF);
    idle(2);
    send(32'h3100_0001);
    send(32'h33FF_FFFF);
    @(negedge clk);
    cmp("R7 blocked while transfer open", 128'(in_ready), 128'd0);
    send(32'hF200_0000);
    comp_lat = 9;
    send(32'hF000_0000);
    cmp("R8 reopened after compute", 128'(err), 128'd0);
    send(32'hF100_0000);
    send(32'hF200_0000);
    idle(12);

    // bad placements
    send(32'h2001_0001);
    expect_err("R4 config while idle");
    do_reset();
    send(32'hF000_0000);
    send(32'hF200_0000);
    expect_err("R4 close in config phase");
    do_reset();
    send(32'hF000_0000);
    send(32'h2008_7777);
    expect_err("R3 index out of range");
    cmp("R3 no register written", cfg_regs, '0);
    do_reset();
    send(32'h5500_0000);
    expect_err("R5 unknown header");
    do_reset();
    send(32'hF000_0000);
    send(32'hF100_0000);
    send(32'h3100_0042);
    expect_err("R6 low word before high");
    do_reset();
    send(32'hF000_0000);
    send(32'hF100_0000);
    send(32'h3000_0011);
    send(32'hF200_0000);
    expect_err("R4 close with open chain");
    send(32'hF000_0000);
    send(32'h2000_9999);
    cmp("R9 still stuck", {126'd0, err, in_ready}, 128'b10);
    cmp("R9 cfg untouched", cfg_regs, '0);
    do_reset();
    send(32'hF000_0000);
    send(32'hF100_0000);
    send(32'h3000_0001);
    send(32'h3100_0002);
    send(32'h2000_0003);
    expect_err("R4 config in move phase");
    do_reset();
    cmp("R1 recovery", {126'd0, err, in_ready}, 128'b01);
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule